// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. It sits beside a shared 16-bit free-running count and, chosen by a mode input, does one of two jobs. As a capture channel it watches an asynchronous input pin, synchronizes it, and on the chosen transition stores the current count in its 16-bit channel register. As a compare channel it holds a value written by software. When the count first reaches that value, it sets a sticky event flag and applies a selected action to its output pin.

Software reaches the 16-bit register through an 8-bit byte port. All bus pins are plain control pins with no handshake: an access takes place on any clock edge where `bus_en` is high. The count value is always the high byte first. A high-byte read freezes the low byte in a holding register, and the following low-byte read returns it. A high-byte write is parked in a buffer, and the whole 16-bit value is committed on the low-byte write. The prescaler, the counter itself and interrupt routing lie outside the block; only the flag leaves it.

Top module: `tcc_channel`

## Requirements
- R1: After reset the channel register reads 0x0000, the event flag and the output pin are 0, and the flag byte (address 2) reads 0x00.
- R2: In capture mode (`mode_oc`=0) with edge select 01, a rising pin transition stores the count into the channel register within three clock cycles, and a falling transition stores nothing.
- R3: Edge select 10 captures only on falling pin transitions, 11 captures on both, and 00 never captures.
- R4: In capture mode, writes to addresses 0 (high byte) and 1 (low byte) have no effect on the channel register or on the buffered high byte.
- R5: In compare mode, a write to address 0 only buffers the byte; the channel register takes the full value {buffered high, written low} on the write to address 1.
- R6: A read of address 0 returns the register's high byte and snapshots its low byte; reads of address 1 return that snapshot, even if the register has since changed.
- R7: In compare mode, on the first clock where the count equals the register, the flag is set on the following edge; a count that stays equal does not raise a second event.
- R8: Writing a byte to address 2 with bit 0 set clears the flag; with bit 0 clear it has no effect. Bit 0 of address 2 reads the flag; its other bits read 0.
- R9: A compare event drives the output pin according to the action field: 00 leave it, 01 toggle, 10 drive 0, 11 drive 1.
- R10: In capture mode a count equal to the register neither sets the flag nor changes the output pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Shared free-running count |
| pin_i | input | 1 | Asynchronous channel input pin |
| mode_oc | input | 1 | 0 capture, 1 compare |
| edge_sel | input | 2 | Capture edge: 00 off, 01 rising, 10 falling, 11 both |
| oc_act | input | 2 | Compare action: 00 none, 01 toggle, 10 low, 11 high |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | 0 high byte, 1 low byte, 2 flag, 3 reserved (reads 0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte (combinational) |
| flag_o | output | 1 | Sticky compare event flag |
| oc_pin_o | output | 1 | Compare output pin |

## Verification
The bench walks the capture channel through every edge-select code and checks that the wrong transition stores nothing. A swapped or ignored select would overwrite the register with the later count. It writes both bytes in capture mode and then commits a low byte in compare mode, which exposes a design that lets the high-byte buffer absorb writes it should have dropped. It changes the register between a high read and a low read, which a design without a snapshot would return as the fresh low byte. It also holds the count on the match value while clearing the flag, so that a level-sensitive compare would show up by setting the flag again.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } oc_act_e;

  typedef enum logic [1:0] {
    ADR_HI   = 2'd0,
    ADR_LO   = 2'd1,
    ADR_FLAG = 2'd2,
    ADR_RSVD = 2'd3
  } bus_addr_e;
endpackage

// File: rtl/tcc_edge_detect.sv
module tcc_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] edge_sel,
  output logic       evt_o
);
  import tcc_pkg::*;

  localparam int CHAIN_LEN = SYNC_STAGES + 1;

  logic [CHAIN_LEN-1:0] chain;
  logic                 cur, prev, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= pin_i;
  end

  generate
    for (genvar s = 1; s < CHAIN_LEN; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign cur  = chain[SYNC_STAGES-1];
  assign prev = chain[SYNC_STAGES];
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    unique case (edge_sel_e'(edge_sel))
      EDGE_RISE: evt_o = rise;
      EDGE_FALL: evt_o = fall;
      EDGE_BOTH: evt_o = rise | fall;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tcc_byte_port.sv
module tcc_byte_port #(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [1:0]         bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  input  logic               wr_allow,
  input  logic [2*BUS_W-1:0] chan_val,
  input  logic               flag_val,
  output logic [BUS_W-1:0]   hi_buf_o,
  output logic               lo_commit_o,
  output logic               flag_clr_o,
  output logic [BUS_W-1:0]   bus_rdata
);
  import tcc_pkg::*;

  localparam int DATA_W = 2 * BUS_W;

  logic [BUS_W-1:0] hi_buf;
  logic [BUS_W-1:0] lo_snap;
  logic             wr, rd;

  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_buf  <= '0;
      lo_snap <= '0;
    end else begin
      if (wr && wr_allow && bus_addr == ADR_HI) hi_buf <= bus_wdata;
      if (rd && bus_addr == ADR_HI) lo_snap <= chan_val[BUS_W-1:0];
    end
  end

  assign hi_buf_o    = hi_buf;
  assign lo_commit_o = wr & wr_allow & (bus_addr == ADR_LO);
  assign flag_clr_o  = wr & (bus_addr == ADR_FLAG) & bus_wdata[0];

  always_comb begin
    unique case (bus_addr_e'(bus_addr))
      ADR_HI:   bus_rdata = chan_val[DATA_W-1:BUS_W];
      ADR_LO:   bus_rdata = lo_snap;
      ADR_FLAG: bus_rdata = {{(BUS_W-1){1'b0}}, flag_val};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tcc_compare.sv
module tcc_compare #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [1:0]       oc_act,
  input  logic             flag_clr,
  output logic             match_evt_o,
  output logic             flag_o,
  output logic             pin_o
);
  import tcc_pkg::*;

  logic match_now, match_q;
  logic flag_q, pin_q;

  assign match_now   = (cnt_i == cmp_i);
  assign match_evt_o = enable & match_now & ~match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      flag_q  <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      match_q <= match_now;
      if (match_evt_o)   flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (match_evt_o) begin
        unique case (oc_act_e'(oc_act))
          ACT_TOGGLE: pin_q <= ~pin_q;
          ACT_LOW:    pin_q <= 1'b0;
          ACT_HIGH:   pin_q <= 1'b1;
          default:    pin_q <= pin_q;
        endcase
      end
    end
  end

  assign flag_o = flag_q;
  assign pin_o  = pin_q;
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel #(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*BUS_W-1:0]   cnt_i,
  input  logic                 pin_i,
  input  logic                 mode_oc,
  input  logic [1:0]           edge_sel,
  input  logic [1:0]           oc_act,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [1:0]           bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic                 flag_o,
  output logic                 oc_pin_o
);
  localparam int DATA_W = 2 * BUS_W;

  logic [DATA_W-1:0] chan_reg;
  logic [BUS_W-1:0]  hi_buf;
  logic              edge_evt, cap_fire, lo_commit, flag_clr, match_evt;

  tcc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_i),
    .edge_sel (edge_sel),
    .evt_o    (edge_evt)
  );

  assign cap_fire = edge_evt & ~mode_oc;

  tcc_byte_port #(.BUS_W(BUS_W)) u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_en      (bus_en),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .wr_allow    (mode_oc),
    .chan_val    (chan_reg),
    .flag_val    (flag_o),
    .hi_buf_o    (hi_buf),
    .lo_commit_o (lo_commit),
    .flag_clr_o  (flag_clr),
    .bus_rdata   (bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chan_reg <= '0;
    else if (cap_fire)  chan_reg <= cnt_i;
    else if (lo_commit) chan_reg <= {hi_buf, bus_wdata};
  end

  tcc_compare #(.CNT_W(DATA_W)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (mode_oc),
    .cnt_i       (cnt_i),
    .cmp_i       (chan_reg),
    .oc_act      (oc_act),
    .flag_clr    (flag_clr),
    .match_evt_o (match_evt),
    .flag_o      (flag_o),
    .pin_o       (oc_pin_o)
  );
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_oc,
  input logic [1:0]        edge_sel,
  input logic [1:0]        oc_act,
  input logic              bus_en,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] cnt_i,
  input logic [DATA_W-1:0] chan_reg,
  input logic              cap_fire,
  input logic              match_evt,
  input logic              flag_o,
  input logic              oc_pin_o
);
  a_r2_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> chan_reg == $past(cnt_i));

  a_r3_off_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_oc && edge_sel == 2'b00) |=> $stable(chan_reg));

  a_r4_ic_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_oc && !cap_fire) |=> $stable(chan_reg));

  a_r5_hi_write_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oc && bus_en && bus_we && bus_addr == 2'd0) |=> $stable(chan_reg));

  a_r7_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> flag_o);

  a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && oc_act == 2'b01) |=> oc_pin_o != $past(oc_pin_o));

  a_r10_no_flag_ic: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_oc && !flag_o) |=> !flag_o);

  a_r10_pin_hold_ic: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_oc |=> $stable(oc_pin_o));
endmodule

bind tcc_channel tcc_channel_chk #(.DATA_W(2*BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_oc   (mode_oc),
  .edge_sel  (edge_sel),
  .oc_act    (oc_act),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .cnt_i     (cnt_i),
  .chan_reg  (chan_reg),
  .cap_fire  (cap_fire),
  .match_evt (match_evt),
  .flag_o    (flag_o),
  .oc_pin_o  (oc_pin_o)
);

// File: tb/tb_tcc_channel.sv
module tb_tcc_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        pin = 1'b0;
  logic        mode_oc = 1'b0;
  logic [1:0]  edge_sel = 2'b00;
  logic [1:0]  oc_act = 2'b00;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        flag_o, oc_pin_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tcc_channel dut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_i(pin), .mode_oc(mode_oc),
    .edge_sel(edge_sel), .oc_act(oc_act), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .flag_o(flag_o), .oc_pin_o(oc_pin_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] h, l;
    bus_read(2'd0, h);
    bus_read(2'd1, l);
    v = {h, l};
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    pin = v;
    wait_cyc(4);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    logic [7:0]  f;
    chk("R1 flag after reset", {15'd0, flag_o}, 16'd0);
    chk("R1 pin after reset", {15'd0, oc_pin_o}, 16'd0);
    read16(v);
    chk("R1 register after reset", v, 16'h0000);
    bus_read(2'd2, f);
    chk("R1 flag byte after reset", {8'd0, f}, 16'h0000);
  endtask

  task automatic t_capture_rise;
    logic [15:0] v;
    edge_sel = 2'b01; cnt = 16'h1234;
    set_pin(1'b1);
    cnt = 16'h2222;
    read16(v);
    chk("R2 rising capture", v, 16'h1234);
    set_pin(1'b0);
    read16(v);
    chk("R2 falling ignored in rise mode", v, 16'h1234);
  endtask

  task automatic t_capture_fall;
    logic [15:0] v;
    edge_sel = 2'b10; cnt = 16'h3333;
    set_pin(1'b1);
    read16(v);
    chk("R3 rising ignored in fall mode", v, 16'h1234);
    set_pin(1'b0);
    read16(v);
    chk("R3 falling capture", v, 16'h3333);
  endtask

  task automatic t_capture_both_off;
    logic [15:0] v;
    edge_sel = 2'b11; cnt = 16'h4444;
    set_pin(1'b1);
    read16(v);
    chk("R3 any-edge rising", v, 16'h4444);
    cnt = 16'h4545;
    set_pin(1'b0);
    read16(v);
    chk("R3 any-edge falling", v, 16'h4545);
    edge_sel = 2'b00; cnt = 16'h5555;
    set_pin(1'b1);
    set_pin(1'b0);
    read16(v);
    chk("R3 disabled edge select", v, 16'h4545);
  endtask

  task automatic t_ic_write_ignored;
    logic [15:0] v;
    bus_write(2'd0, 8'hAB);
    bus_write(2'd1, 8'hCD);
    read16(v);
    chk("R4 capture-mode write ignored", v, 16'h4545);
    cnt = 16'h0F0F;
    @(negedge clk); mode_oc = 1'b1;
    bus_write(2'd1, 8'h11);
    read16(v);
    chk("R4 high buffer untouched in capture mode", v, 16'h0011);
  endtask

  task automatic t_oc_write;
    logic [15:0] v;
    logic [7:0]  h;
    bus_write(2'd0, 8'h12);
    bus_read(2'd0, h);
    chk("R5 high write only buffered", {8'd0, h}, 16'h0000);
    bus_write(2'd1, 8'h34);
    read16(v);
    chk("R5 commit on low write", v, 16'h1234);
  endtask

  task automatic t_snapshot;
    logic [15:0] v;
    logic [7:0]  h, l;
    bus_read(2'd0, h);
    chk("R6 high read", {8'd0, h}, 16'h0012);
    bus_write(2'd0, 8'h56);
    bus_write(2'd1, 8'h78);
    bus_read(2'd1, l);
    chk("R6 low read returns snapshot", {8'd0, l}, 16'h0034);
    read16(v);
    chk("R6 coherent read after update", v, 16'h5678);
  endtask

  task automatic t_match_flag;
    logic [7:0] f;
    bus_write(2'd2, 8'h01);
    oc_act = 2'b01;
    @(negedge clk); cnt = 16'h5677;
    @(negedge clk);
    chk("R7 no flag before match", {15'd0, flag_o}, 16'd0);
    cnt = 16'h5678;
    @(negedge clk);
    chk("R7 flag on match", {15'd0, flag_o}, 16'd1);
    chk("R9 toggle action", {15'd0, oc_pin_o}, 16'd1);
    bus_read(2'd2, f);
    chk("R8 flag byte reads set", {8'd0, f}, 16'h0001);
    bus_write(2'd2, 8'hFE);
    chk("R8 write without bit 0 keeps flag", {15'd0, flag_o}, 16'd1);
    bus_write(2'd2, 8'h01);
    chk("R8 write-one clears flag", {15'd0, flag_o}, 16'd0);
    wait_cyc(2);
    chk("R7 no repeat while count stays equal", {15'd0, flag_o}, 16'd0);
  endtask

  task automatic do_match(input logic [1:0] act, input logic exp, input string tag);
    @(negedge clk); cnt = 16'h0000;
    @(negedge clk); oc_act = act; cnt = 16'h5678;
    @(negedge clk);
    chk(tag, {15'd0, oc_pin_o}, {15'd0, exp});
  endtask

  task automatic t_actions;
    do_match(2'b10, 1'b0, "R9 drive-low action");
    do_match(2'b11, 1'b1, "R9 drive-high action");
    do_match(2'b00, 1'b1, "R9 no-action keeps pin");
    do_match(2'b01, 1'b0, "R9 toggle from high");
    do_match(2'b11, 1'b1, "R9 drive-high again");
  endtask

  task automatic t_ic_no_compare;
    bus_write(2'd2, 8'h01);
    @(negedge clk); mode_oc = 1'b0; edge_sel = 2'b00; oc_act = 2'b01; cnt = 16'h0000;
    @(negedge clk); cnt = 16'h5678;
    wait_cyc(2);
    chk("R10 no flag in capture mode", {15'd0, flag_o}, 16'd0);
    chk("R10 pin held in capture mode", {15'd0, oc_pin_o}, 16'd1);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_capture_rise();
    t_capture_fall();
    t_capture_both_off();
    t_ic_write_ignored();
    t_oc_write();
    t_snapshot();
    t_match_flag();
    t_actions();
    t_ic_no_compare();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule